// File: doc/BRIEF.md
# DMA Channel Request-Enable Set Port

This block holds the per-channel request-enable vector of a DMA controller and gives software a compact way to turn channels on. Each channel has one enable bit. The arbiter watches the vector and serves only channels whose bit is set. There are 64 channels by default, in a low and a high 32-bit half; a 32-channel build has only the low half.

Software turns channels on with a one-byte set command. Bit 7 of the byte is a skip flag, and the low seven bits are the command code. With the skip flag clear, a code below 64 names a single channel, and that channel's enable bit is set. A code of 64 or above sets every enable bit. Setting never clears a bit. The command word has four byte lanes, and each lane decodes on its own. Several commands can therefore share one 32-bit write, and a lane whose skip flag is set does nothing. The command word reads as zero. The two enable halves can also be read and written directly as ordinary 32-bit registers with byte strobes.

Word addresses on the 2-bit `bus_addr`:

| Address | Register |
|---|---|
| 0 | enable bits 31..0 |
| 1 | enable bits 63..32 |
| 2 | set-command word |
| 3 | unused, reads zero |

Top module: `dma_reqen_set_port`

## Requirements
- R1: After reset, `req_enable` is all zeroes and every address reads zero.
- R2: A command byte with bit 7 set changes no enable bit, whatever bits 6..0 hold.
- R3: A command byte with bit 7 clear and a code of 0 to 63 sets enable bit [code]. Bits 0..31 are in the low half and bits 32..63 in the high half. No other bit changes.
- R4: A command byte with bit 7 clear and a code of 64 to 127 (bit 6 set) sets every enable bit.
- R5: A read of the command word at address 2 returns zero, and so does a read of address 3.
- R6: The four byte lanes of the command word are decoded independently. Their effects are ORed and applied in the same cycle. A lane whose strobe is low is ignored.
- R7: When CHANNELS is 32, codes 32 to 63 have no effect and codes 64 to 127 set all 32 bits. Address 1 reads zero, and writes to it are ignored.
- R8: A write to address 0 or 1 replaces the enable bytes whose `bus_wstrb` bit is 1 and leaves the other bytes unchanged.
- R9: An enable change caused by a write appears on `req_enable` and in reads in the cycle after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Word address |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| req_enable | output | CHANNELS | Per-channel request-enable vector for the arbiter |

## Verification
A write takes effect on the clock edge that samples it, so `req_enable` and read data show the new vector one cycle later. Read data is combinational, so it is valid in the same cycle as the address.

The bench drives every write on a falling edge and releases it on the next falling edge, after one rising edge has passed. It compares `req_enable` at that point. It reads by setting the address on a falling edge and sampling shortly afterwards. A 64-channel and a 32-channel instance share the same bus, so every command is also checked against the reduced channel map.

// File: rtl/dma_reqen_pkg.sv
package dma_reqen_pkg;
  localparam int MAX_CH    = 64;
  localparam int LANES     = 4;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ADDR_EN_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMD   = 2'd2;

  // Enable bits that one command byte sets in a build with chans channels.
  function automatic logic [MAX_CH-1:0] cmd_mask(input logic [7:0] cmd, input int chans);
    logic [MAX_CH-1:0] m;
    m = '0;
    if (!cmd[7]) begin
      if (cmd[6]) begin
        for (int i = 0; i < MAX_CH; i++) m[i] = (i < chans);
      end else if (int'(cmd[5:0]) < chans) begin
        m[cmd[5:0]] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic cmd_is_global(input logic [7:0] cmd);
    return !cmd[7] && cmd[6];
  endfunction
endpackage

// File: rtl/reqen_cmd_lane.sv
module reqen_cmd_lane
  import dma_reqen_pkg::*;
#(
  parameter int CHANNELS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lane_en,
  input  logic [7:0]          cmd_byte,
  output logic [CHANNELS-1:0] lane_mask,
  output logic                lane_global
);
  logic [MAX_CH-1:0] full_mask;

  always_comb begin
    full_mask   = lane_en ? cmd_mask(cmd_byte, CHANNELS) : '0;
    lane_global = lane_en && cmd_is_global(cmd_byte);
  end

  assign lane_mask = full_mask[CHANNELS-1:0];

  // R2: a lane carrying the skip flag contributes nothing
  a_r2_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && cmd_byte[7]) |-> (lane_mask == '0));

  // R3: a single-channel command sets at most one bit
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && !cmd_byte[7] && !cmd_byte[6]) |-> $onehot0(lane_mask));
endmodule

// File: rtl/reqen_vector.sv
module reqen_vector
  import dma_reqen_pkg::*;
#(
  parameter int CHANNELS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [LANES-1:0]    wstrb,
  input  logic [31:0]         wdata,
  input  logic [CHANNELS-1:0] set_mask,
  output logic [CHANNELS-1:0] vec
);
  localparam int HALVES = CHANNELS / 32;

  logic [CHANNELS-1:0] written;
  logic [CHANNELS-1:0] vec_next;
  logic                dir_wr_any;

  always_comb begin
    written = vec;
    for (int h = 0; h < HALVES; h++) begin
      for (int b = 0; b < LANES; b++) begin
        if (((h == 0) ? wr_lo : wr_hi) && wstrb[b])
          written[h*32 + b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
    vec_next = written | set_mask;
  end

  assign dir_wr_any = wr_lo || (wr_hi && (HALVES > 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec <= '0;
    else        vec <= vec_next;
  end

  // R1: vector is clear when reset releases
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vec == '0));

  // R3: without a direct write, no enabled bit is ever dropped
  a_r3_set_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr_any |=> ((vec & $past(vec)) == $past(vec)));

  // R9: requested set bits are present one cycle later
  a_r9_set_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((vec & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/reqen_read_mux.sv
module reqen_read_mux
  import dma_reqen_pkg::*;
#(
  parameter int CHANNELS = 64
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CHANNELS-1:0] vec,
  output logic [31:0]         rdata
);
  logic [MAX_CH-1:0] padded;

  always_comb begin
    padded = '0;
    padded[CHANNELS-1:0] = vec;
    unique case (addr)
      ADDR_EN_LO: rdata = padded[31:0];
      ADDR_EN_HI: rdata = padded[63:32];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_reqen_set_port.sv
module dma_reqen_set_port
  import dma_reqen_pkg::*;
#(
  parameter int CHANNELS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [3:0]          bus_wstrb,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [CHANNELS-1:0] req_enable
);
  logic                cmd_hit;
  logic                wr_lo;
  logic                wr_hi;
  logic [LANES-1:0]    lane_en;
  logic [LANES-1:0]    lane_global;
  logic [CHANNELS-1:0] lane_mask [LANES];
  logic [CHANNELS-1:0] set_mask;
  logic                any_global;

  assign cmd_hit = bus_wr && (bus_addr == ADDR_CMD);
  assign wr_lo   = bus_wr && (bus_addr == ADDR_EN_LO);
  assign wr_hi   = bus_wr && (bus_addr == ADDR_EN_HI);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = cmd_hit && bus_wstrb[l];
    reqen_cmd_lane #(.CHANNELS(CHANNELS)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_en    (lane_en[l]),
      .cmd_byte   (bus_wdata[l*8 +: 8]),
      .lane_mask  (lane_mask[l]),
      .lane_global(lane_global[l])
    );
  end

  always_comb begin
    set_mask = '0;
    for (int l = 0; l < LANES; l++) set_mask = set_mask | lane_mask[l];
  end

  assign any_global = |lane_global;

  reqen_vector #(.CHANNELS(CHANNELS)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wstrb   (bus_wstrb),
    .wdata   (bus_wdata),
    .set_mask(set_mask),
    .vec     (req_enable)
  );

  reqen_read_mux #(.CHANNELS(CHANNELS)) u_rd (
    .addr (bus_addr),
    .vec  (req_enable),
    .rdata(bus_rdata)
  );

  // R4: a global code in any lane fills the vector on the next cycle
  a_r4_global_fill: assert property (@(posedge clk) disable iff (!rst_n)
    any_global |=> (req_enable == {CHANNELS{1'b1}}));

  // R5: the command word always reads zero
  a_r5_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CMD) |-> (bus_rdata == '0));

  // R7: a build without a high half reads zero there
  if (CHANNELS <= 32) begin : g_small_chk
    a_r7_no_high_half: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_EN_HI) |-> (bus_rdata == '0));
  end
endmodule

// File: tb/dma_reqen_set_port_bench.sv
module dma_reqen_set_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [3:0]  bus_wstrb = 4'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_big, rdata_small;
  logic [63:0] en_big;
  logic [31:0] en_small;

  logic [63:0] exp_big = '0;
  logic [31:0] exp_small = '0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_reqen_set_port #(.CHANNELS(64)) u_dma_reqen_set_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_big), .req_enable(en_big));

  dma_reqen_set_port #(.CHANNELS(32)) u_small (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_small), .req_enable(en_small));

  // Bench model of one command byte.
  function automatic logic [63:0] model_set(input logic [7:0] b, input int chans);
    logic [63:0] ones;
    ones = (chans == 64) ? {64{1'b1}} : {32'd0, {32{1'b1}}};
    if (b >= 8'd128)     return 64'd0;
    else if (b >= 8'd64) return ones;
    else if (int'(b) < chans) return 64'd1 << b;
    else return 64'd0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic chk_vec(input string tag);
    chk({tag, " big vec"}, en_big, exp_big);
    chk({tag, " small vec"}, {32'd0, en_small}, {32'd0, exp_small});
  endtask

  task automatic do_write(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wstrb = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = 4'd0;
    for (int b = 0; b < 4; b++) begin
      if (s[b]) begin
        if (a == 2'd0) begin
          exp_big[b*8 +: 8] = d[b*8 +: 8];
          exp_small[b*8 +: 8] = d[b*8 +: 8];
        end else if (a == 2'd1) begin
          exp_big[32 + b*8 +: 8] = d[b*8 +: 8];
        end else if (a == 2'd2) begin
          exp_big = exp_big | model_set(d[b*8 +: 8], 64);
          exp_small = exp_small | model_set(d[b*8 +: 8], 32)[31:0];
        end
      end
    end
  endtask

  task automatic chk_read(input string tag, input logic [1:0] a);
    logic [31:0] eb, es;
    @(negedge clk);
    bus_addr = a;
    #1;
    eb = (a == 2'd0) ? exp_big[31:0] : (a == 2'd1) ? exp_big[63:32] : 32'd0;
    es = (a == 2'd0) ? exp_small : 32'd0;
    chk({tag, " big read"}, {32'd0, rdata_big}, {32'd0, eb});
    chk({tag, " small read"}, {32'd0, rdata_small}, {32'd0, es});
  endtask

  task automatic clear_all();
    do_write(2'd0, 4'hF, 32'd0);
    do_write(2'd1, 4'hF, 32'd0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_vec("R1 reset");
    for (int a = 0; a < 4; a++) chk_read("R1 reset", 2'(a));

    // R2 skip flag on all lanes, including codes that would otherwise act
    do_write(2'd2, 4'hF, 32'hC0_85_FF_80);
    chk_vec("R2 nop lanes");

    // R3 single channels at the half boundaries
    do_write(2'd2, 4'h1, 32'h0000_0000);
    chk_vec("R3 ch0");
    do_write(2'd2, 4'h2, 32'h0000_3F00);
    chk_vec("R3 ch63");
    do_write(2'd2, 4'h4, 32'h0020_0000);
    chk_vec("R3 ch32 / R7 small ignores 32");
    do_write(2'd2, 4'h8, 32'h1F00_0000);
    chk_vec("R3 ch31");
    chk_read("R3 low", 2'd0);
    chk_read("R3 high", 2'd1);

    // R6 lanes with low strobe ignored, active lanes combined
    clear_all();
    do_write(2'd2, 4'h5, 32'h0305_0107);
    chk_vec("R6 strobe mask");
    do_write(2'd2, 4'hF, 32'h2A_8C_11_22);
    chk_vec("R6 multi lane");

    // R4 global codes 64 and 127
    clear_all();
    do_write(2'd2, 4'h1, 32'h0000_0040);
    chk_vec("R4 code 64");
    clear_all();
    do_write(2'd2, 4'h8, 32'h7F00_0000);
    chk_vec("R4 code 127");

    // R5 command word and unused address read zero
    chk_read("R5 cmd", 2'd2);
    chk_read("R5 unused", 2'd3);

    // R8 direct byte-strobed writes; R7 high-half write ignored in small build
    do_write(2'd0, 4'h6, 32'hA5A5_A5A5);
    chk_vec("R8 low strobes");
    do_write(2'd1, 4'h9, 32'h1234_5678);
    chk_vec("R8 high strobes");
    chk_read("R7 high half", 2'd1);

    // R9 change shown exactly one cycle after the write edge
    clear_all();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wstrb = 4'h1; bus_wdata = 32'd9;
    #1 chk("R9 before edge", en_big, 64'd0);
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = 4'd0;
    exp_big[9] = 1'b1; exp_small[9] = 1'b1;
    chk_vec("R9 after edge");

    // Random mix (R3 R4 R6 R8)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      logic [3:0] s;
      int kind;
      kind = int'($urandom_range(0, 9));
      s = 4'($urandom);
      d = $urandom;
      for (int b = 0; b < 4; b++)
        if (d[b*8 + 6] && ($urandom_range(0, 7) != 0)) d[b*8 + 6] = 1'b0;
      if (kind == 0)      do_write(2'd0, s, d);
      else if (kind == 1) do_write(2'd1, s, d);
      else if (kind == 2) clear_all();
      else                do_write(2'd2, s, d);
      chk_vec("R3/R4/R6 random");
      if (n % 8 == 0) chk_read("R8 random read", 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule